// File: doc/BRIEF.md
# Preset Clock Level Register Bank

This block holds eight preset clock configurations for one clock root and picks which of them drives the root's live settings. Each preset carries a configuration word (pre-divider, source select, mode) and an M and N value. Software programs the presets and a control register over a simple register write/read bus. A consumer then switches between presets by presenting a level index, with no software involvement at switch time.

While preset switching is enabled, the live outputs come from the preset that the consumer last selected. While it is disabled, the live outputs pass the root's normal configuration inputs through unchanged. The control register also reports which level is currently selected, so software can read back the consumer's choice.

Top module: `lvl_cfg_bank`

## Requirements
- R1: Exactly eight levels exist. Level l has its configuration word at byte offset 0x1C+4*l, its M value at 0x5C+4*l and its N value at 0x9C+4*l. Writes to these offsets store the low bits of the write data (configuration: CFG_W bits, M/N: MN_W bits), and reads return them zero-extended.
- R2: The control register is at offset 0x14. Bit 0 is the enable bit and can be written and read. Bits 4:1 read as the current level. All other bits read as zero.
- R3: A configuration word uses the same field layout in the presets and on the normal inputs: pre-divider in bits DIV_W-1:0, source select in bits 10:8, mode in bits 13:12.
- R4: A valid level request (`lvl_req_vld` high with `lvl_req` below 8) updates the current level on the next rising clock edge. The control register then reports the new level, and so do the live outputs when switching is enabled.
- R5: A request of 8 or above is ignored and the previous level is kept.
- R6: With the enable bit set, the live pre-divider, source, mode, M and N outputs equal the fields of the current level's stored registers. This includes the same cycle in which a preset register is rewritten through the bus, after its clock edge.
- R7: With the enable bit clear, the live outputs equal the normal configuration and M/N inputs unchanged, with no added delay.
- R8: After reset, the enable bit is clear, the current level is 0, and every preset register holds zero.
- R9: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| lvl_req_vld | input | 1 | Consumer level request strobe |
| lvl_req | input | 4 | Requested level index |
| norm_cfg | input | 32 | Normal configuration word |
| norm_m | input | MN_W | Normal M value |
| norm_n | input | MN_W | Normal N value |
| live_div | output | DIV_W | Selected pre-divider |
| live_src | output | 3 | Selected source select |
| live_mode | output | 2 | Selected mode |
| live_m | output | MN_W | Selected M value |
| live_n | output | MN_W | Selected N value |

## Verification
The bench steers toward four corner cases. The first is requests of 8 and 15: a design that truncates the index to three bits would jump to level 0 or 7 instead of keeping its level. The second is writes to the last level's N slot and to an offset just beyond it: a wrong offset decode would corrupt level 7 or a neighbouring level. The third is toggling the enable bit while the normal inputs change: a design that registered the pass-through path would lag by one cycle. The fourth is rewriting the currently selected preset: the live outputs must take the new value right after the write edge.

// File: rtl/lvl_cfg_pkg.sv
package lvl_cfg_pkg;
   localparam int NUM_LVL      = 8;
   localparam int LVL_IDX_W    = 4;
   localparam int CTRL_OFS     = 'h14;
   localparam int CFG_BASE     = 'h1C;
   localparam int M_BASE       = 'h5C;
   localparam int N_BASE       = 'h9C;
   localparam int SRC_LSB      = 8;
   localparam int SRC_W        = 3;
   localparam int MODE_LSB     = 12;
   localparam int MODE_W       = 2;

   typedef enum logic [1:0] {
      SLOT_NONE = 2'd0,
      SLOT_CFG  = 2'd1,
      SLOT_M    = 2'd2,
      SLOT_N    = 2'd3
   } slot_kind_e;
endpackage

// File: rtl/lvl_addr_dec.sv
module lvl_addr_dec
   import lvl_cfg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              is_ctrl,
   output slot_kind_e        kind,
   output logic [2:0]        lvl
);
   localparam int SPAN = 4 * NUM_LVL;

   initial begin
      if (ADDR_W < 8) $error("ADDR_W too small for the level map");
   end

   always_comb begin
      int a;
      a       = int'(addr);
      is_ctrl = (a == CTRL_OFS);
      kind    = SLOT_NONE;
      lvl     = '0;
      if (a[1:0] == 2'b00) begin
         if (a >= CFG_BASE && a < CFG_BASE + SPAN) begin
            kind = SLOT_CFG;
            lvl  = 3'((a - CFG_BASE) >> 2);
         end else if (a >= M_BASE && a < M_BASE + SPAN) begin
            kind = SLOT_M;
            lvl  = 3'((a - M_BASE) >> 2);
         end else if (a >= N_BASE && a < N_BASE + SPAN) begin
            kind = SLOT_N;
            lvl  = 3'((a - N_BASE) >> 2);
         end
      end
   end
endmodule

// File: rtl/lvl_preset_store.sv
module lvl_preset_store
   import lvl_cfg_pkg::*;
#(
   parameter int CFG_W = 14,
   parameter int MN_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  slot_kind_e       kind,
   input  logic [2:0]       wr_lvl,
   input  logic [31:0]      wdata,
   input  logic [2:0]       rd_lvl,
   output logic [CFG_W-1:0] rd_cfg,
   output logic [MN_W-1:0]  rd_m,
   output logic [MN_W-1:0]  rd_n,
   input  logic [2:0]       sel_lvl,
   output logic [CFG_W-1:0] sel_cfg,
   output logic [MN_W-1:0]  sel_m,
   output logic [MN_W-1:0]  sel_n
);
   logic [CFG_W-1:0] cfg_q [NUM_LVL];
   logic [MN_W-1:0]  m_q   [NUM_LVL];
   logic [MN_W-1:0]  n_q   [NUM_LVL];

   initial begin
      if (CFG_W < MODE_LSB + MODE_W) $error("CFG_W must hold the mode field");
      if (MN_W > 32) $error("MN_W must fit the data bus");
   end

   for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[g] <= '0;
            m_q[g]   <= '0;
            n_q[g]   <= '0;
         end else if (wr && wr_lvl == 3'(g)) begin
            case (kind)
               SLOT_CFG: cfg_q[g] <= wdata[CFG_W-1:0];
               SLOT_M:   m_q[g]   <= wdata[MN_W-1:0];
               SLOT_N:   n_q[g]   <= wdata[MN_W-1:0];
               default: ;
            endcase
         end
      end
   end

   assign rd_cfg  = cfg_q[rd_lvl];
   assign rd_m    = m_q[rd_lvl];
   assign rd_n    = n_q[rd_lvl];
   assign sel_cfg = cfg_q[sel_lvl];
   assign sel_m   = m_q[sel_lvl];
   assign sel_n   = n_q[sel_lvl];
endmodule

// File: rtl/lvl_select.sv
module lvl_select
   import lvl_cfg_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_vld,
   input  logic [LVL_IDX_W-1:0] req,
   output logic [2:0]           cur_lvl
);
   logic req_ok;
   assign req_ok = req_vld && (int'(req) < NUM_LVL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cur_lvl <= '0;
      else if (req_ok) cur_lvl <= req[2:0];
   end

   AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && int'(req) < NUM_LVL) |=> (cur_lvl == $past(req[2:0]))); // R4
   AST_BAD_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_vld && int'(req) < NUM_LVL) |=> $stable(cur_lvl)); // R5
endmodule

// File: rtl/lvl_cfg_bank.sv
module lvl_cfg_bank
   import lvl_cfg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DIV_W  = 5,
   parameter int MN_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              lvl_req_vld,
   input  logic [3:0]        lvl_req,
   input  logic [31:0]       norm_cfg,
   input  logic [MN_W-1:0]   norm_m,
   input  logic [MN_W-1:0]   norm_n,
   output logic [DIV_W-1:0]  live_div,
   output logic [2:0]        live_src,
   output logic [1:0]        live_mode,
   output logic [MN_W-1:0]   live_m,
   output logic [MN_W-1:0]   live_n
);
   localparam int CFG_W = MODE_LSB + MODE_W;

   initial begin
      if (DIV_W < 1 || DIV_W > SRC_LSB) $error("DIV_W must be 1..8");
      if (MN_W < 1 || MN_W > 32) $error("MN_W must be 1..32");
   end

   logic             is_ctrl;
   slot_kind_e       kind;
   logic [2:0]       dec_lvl;
   logic             en_q;
   logic [2:0]       cur_lvl;
   logic [CFG_W-1:0] rd_cfg, sel_cfg;
   logic [MN_W-1:0]  rd_m, rd_n, sel_m, sel_n;
   logic [CFG_W-1:0] act_cfg;
   logic [MN_W-1:0]  act_m, act_n;

   lvl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .is_ctrl(is_ctrl), .kind(kind), .lvl(dec_lvl)
   );

   lvl_preset_store #(.CFG_W(CFG_W), .MN_W(MN_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .kind(kind), .wr_lvl(dec_lvl),
      .wdata(bus_wdata), .rd_lvl(dec_lvl), .rd_cfg(rd_cfg), .rd_m(rd_m),
      .rd_n(rd_n), .sel_lvl(cur_lvl), .sel_cfg(sel_cfg), .sel_m(sel_m),
      .sel_n(sel_n)
   );

   lvl_select u_sel (
      .clk(clk), .rst_n(rst_n), .req_vld(lvl_req_vld), .req(lvl_req),
      .cur_lvl(cur_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 en_q <= 1'b0;
      else if (bus_wr && is_ctrl) en_q <= bus_wdata[0];
   end

   always_comb begin
      bus_rdata = '0;
      if (is_ctrl) begin
         bus_rdata[0]   = en_q;
         bus_rdata[4:1] = {1'b0, cur_lvl};
      end else begin
         case (kind)
            SLOT_CFG: bus_rdata[CFG_W-1:0] = rd_cfg;
            SLOT_M:   bus_rdata[MN_W-1:0]  = rd_m;
            SLOT_N:   bus_rdata[MN_W-1:0]  = rd_n;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign act_cfg   = en_q ? sel_cfg : norm_cfg[CFG_W-1:0];
   assign act_m     = en_q ? sel_m   : norm_m;
   assign act_n     = en_q ? sel_n   : norm_n;
   assign live_div  = act_cfg[DIV_W-1:0];
   assign live_src  = act_cfg[SRC_LSB +: SRC_W];
   assign live_mode = act_cfg[MODE_LSB +: MODE_W];
   assign live_m    = act_m;
   assign live_n    = act_n;

   AST_BYPASS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (live_src == norm_cfg[10:8] && live_mode == norm_cfg[13:12])); // R7
   AST_BYPASS_MN: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (live_m == norm_m && live_n == norm_n)); // R7
   AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      is_ctrl |-> (bus_rdata[31:5] == '0 && bus_rdata[4] == 1'b0)); // R2
   AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_ctrl) |=> (en_q == $past(bus_wdata[0]))); // R2
   AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_ctrl && kind == SLOT_NONE) |-> bus_rdata == '0); // R9
endmodule

// File: tb/lvl_cfg_bank_test.sv
module lvl_cfg_bank_test;
   localparam int MN_W = 16;
   localparam int DIV_W = 5;

   logic clk = 0, rst_n = 0;
   logic bus_wr = 0;
   logic [7:0] bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic lvl_req_vld = 0;
   logic [3:0] lvl_req = 0;
   logic [31:0] norm_cfg = 0;
   logic [MN_W-1:0] norm_m = 0, norm_n = 0;
   logic [DIV_W-1:0] live_div;
   logic [2:0] live_src;
   logic [1:0] live_mode;
   logic [MN_W-1:0] live_m, live_n;

   int errors = 0, checks = 0;

   // reference model state
   int m_cfg[8], m_m[8], m_n[8];
   int m_en = 0, m_lvl = 0;

   always #2.5 clk = ~clk;

   lvl_cfg_bank uut (.*);

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // model updated at each edge from inputs present before it
   always @(posedge clk) if (rst_n) begin
      int a;
      a = int'(bus_addr);
      if (bus_wr) begin
         if (a == 'h14) m_en = bus_wdata[0];
         else if (a >= 'h1C && a < 'h3C && a % 4 == 0) m_cfg[(a-'h1C)/4] = bus_wdata & 'h3FFF;
         else if (a >= 'h5C && a < 'h7C && a % 4 == 0) m_m[(a-'h5C)/4] = bus_wdata & 'hFFFF;
         else if (a >= 'h9C && a < 'hBC && a % 4 == 0) m_n[(a-'h9C)/4] = bus_wdata & 'hFFFF;
      end
      if (lvl_req_vld && lvl_req < 8) m_lvl = lvl_req;
   end

   // live outputs compared every cycle on the falling edge
   always @(negedge clk) if (rst_n) begin
      int c, em, en_;
      c   = m_en ? m_cfg[m_lvl] : int'(norm_cfg);
      em  = m_en ? m_m[m_lvl] : int'(norm_m);
      en_ = m_en ? m_n[m_lvl] : int'(norm_n);
      chk(m_en ? "R6 div" : "R7 div", live_div, c & 'h1F);
      chk("R3 src", live_src, (c >> 8) & 7);
      chk("R3 mode", live_mode, (c >> 12) & 3);
      chk(m_en ? "R6 m" : "R7 m", live_m, em);
      chk(m_en ? "R6 n" : "R7 n", live_n, en_);
   end

   function automatic int exp_read(int a);
      if (a == 'h14) return m_en | (m_lvl << 1);
      if (a >= 'h1C && a < 'h3C && a % 4 == 0) return m_cfg[(a-'h1C)/4];
      if (a >= 'h5C && a < 'h7C && a % 4 == 0) return m_m[(a-'h5C)/4];
      if (a >= 'h9C && a < 'hBC && a % 4 == 0) return m_n[(a-'h9C)/4];
      return 0;
   endfunction

   task automatic wr(int a, int d);
      bus_addr = 8'(a); bus_wdata = d; bus_wr = 1;
      @(posedge clk); #1 bus_wr = 0;
   endtask

   task automatic rd(string req, int a);
      bus_addr = 8'(a); #1;
      chk(req, bus_rdata, exp_read(a));
   endtask

   task automatic req(int l);
      lvl_req = 4'(l); lvl_req_vld = 1;
      @(posedge clk); #1 lvl_req_vld = 0;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin m_cfg[i] = 0; m_m[i] = 0; m_n[i] = 0; end
      #1 rst_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R8 reset state
      rd("R8 ctrl", 'h14);
      rd("R8 cfg7", 'h38);
      rd("R8 n0", 'h9C);
      // R7 bypass with changing normal inputs
      norm_cfg = 32'h0000_2A13; norm_m = 16'h1234; norm_n = 16'hBEEF;
      @(posedge clk); #1;
      norm_cfg = 32'hFFFF_3705; norm_m = 16'h0001; norm_n = 16'h8000;
      @(posedge clk); #1;
      // R1 program all levels
      for (int l = 0; l < 8; l++) begin
         wr('h1C + 4*l, 32'hFFFF_0000 | ((l%4) << 12) | (((l+3)%8) << 8) | (l*3+1));
         wr('h5C + 4*l, 32'hAB00_0000 | (l*16'h111 + 5));
         wr('h9C + 4*l, 32'h0000_F000 | l);
      end
      for (int l = 0; l < 8; l++) begin
         rd("R1 cfg", 'h1C + 4*l);
         rd("R1 m", 'h5C + 4*l);
         rd("R1 n", 'h9C + 4*l);
      end
      // R9 unmapped writes and reads
      wr('hBC, 32'hDEAD_BEEF);
      wr('h1E, 32'h1234_5678);
      wr('h18, 32'h1);
      rd("R9 rd BC", 'hBC);
      rd("R9 rd 1E", 'h1E);
      rd("R9 n7", 'hB8);
      rd("R9 cfg0", 'h1C);
      rd("R9 ctrl", 'h14);
      // R2 enable
      wr('h14, 32'hFFFF_FFE1);
      rd("R2 ctrl", 'h14);
      // R4 level changes
      req(5); rd("R4 lvl5", 'h14);
      req(7); rd("R4 lvl7", 'h14);
      req(0); rd("R4 lvl0", 'h14);
      req(3); rd("R4 lvl3", 'h14);
      // R5 ignored requests
      req(8);  rd("R5 req8", 'h14);
      req(15); rd("R5 req15", 'h14);
      req(11); rd("R5 req11", 'h14);
      // R6 rewrite active level
      wr('h28, 32'h0000_1207);
      wr('h68, 32'h0000_4242);
      req(6);
      wr('h34, 32'h0000_3111);
      // R7 disable again, normal inputs drive
      wr('h14, 32'h0);
      rd("R2 ctrl off", 'h14);
      norm_cfg = 32'h0000_1102; @(posedge clk); #1;
      req(2); rd("R4 lvl while off", 'h14);
      wr('h14, 32'h1);
      @(posedge clk); #1;
      rd("R6 ctrl", 'h14);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule